// File: doc/BRIEF.md
# Delayed-start event stream follower

This block watches a single-bit event line and passes it through only after a set number of events have gone by. Each clock cycle in which the input is sampled high counts as one event. The first K-1 events are held back. The output rises in the same cycle as the K-th event. From that cycle onward the output is an exact, cycle-for-cycle copy of the input.

The gate stays open until the next synchronous reset. The count never wraps. A reset clears the count and closes the gate, and counting starts again in the first cycle after reset is released. The output is formed combinationally from the input and the registered state, so it is never a cycle late. K is a parameter with a default of 5.

Top module: `delayed_follow`

## Requirements
- R1: While `rst` is sampled high, `ev_out` is 0, and that cycle's `ev_in` is not counted as an event.
- R2: `ev_out` is 0 in every cycle up to and including the (K-1)-th event after reset, whatever number of idle cycles separates those events.
- R3: In the cycle of the K-th event after reset, `ev_out` is 1 in that same cycle, together with `ev_in`.
- R4: In every cycle after the K-th event, `ev_out` equals `ev_in` in the same cycle, with no added delay.
- R5: Each cycle with `ev_in` high counts as a separate event, so K back-to-back high cycles open the gate on the K-th one.
- R6: Once open, the gate stays open for any length of input activity until a reset, and the event count does not wrap.
- R7: A reset in the middle of a count discards the events seen so far, and K fresh events are needed after it.
- R8: The default value of the parameter `K_START` is 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_in | input | 1 | Event input; one event per cycle sampled high |
| ev_out | output | 1 | Gated copy of `ev_in` |

## Verification
`ev_out` depends on `ev_in` in the same cycle and on state that was last updated at the previous rising edge. The bench therefore drives `ev_in` and `rst` on the falling edge, reads `ev_out` a nanosecond later in that same half-cycle, and compares it with a behavioural model that uses an integer event count and an open flag. The model takes each new state at the next rising edge, which is the edge where the design's registers change. A reset affects the output in the cycle it is applied, and the count it clears applies from the following cycle.

// File: rtl/delayed_follow_pkg.sv
package delayed_follow_pkg;

  // Next value of the event counter: advance on an event, hold otherwise.
  function automatic int unsigned count_step(input int unsigned cur, input bit ev);
    return ev ? cur + 1 : cur;
  endfunction

  // True when the counter already holds K-1 events, so the next event is the K-th.
  function automatic bit at_final(input int unsigned cur, input int unsigned k);
    return cur == (k - 1);
  endfunction

endpackage

// File: rtl/df_tick_counter.sv
module df_tick_counter #(
  parameter int unsigned K_START = 5,
  parameter int unsigned CNT_W   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_in,
  output logic final_tick,
  output logic gate_open
);
  import delayed_follow_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign final_tick = at_final(32'(cnt_q), K_START);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      gate_open <= 1'b0;
    end else if (ev_in && !gate_open) begin
      if (final_tick) gate_open <= 1'b1;
      else            cnt_q     <= CNT_W'(count_step(32'(cnt_q), 1'b1));
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) < K_START);
endmodule

// File: rtl/df_out_gate.sv
module df_out_gate (
  input  logic rst,
  input  logic ev_in,
  input  logic gate_open,
  input  logic final_tick,
  output logic ev_out
);
  always_comb begin
    ev_out = 1'b0;
    if (!rst && ev_in && (gate_open || final_tick)) ev_out = 1'b1;
  end
endmodule

// File: rtl/delayed_follow.sv
module delayed_follow #(
  parameter int unsigned K_START = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_in,
  output logic ev_out
);
  localparam int unsigned CNT_W = (K_START < 2) ? 1 : $clog2(K_START);

  logic final_tick;
  logic gate_open;

  df_tick_counter #(.K_START(K_START), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ev_in(ev_in),
    .final_tick(final_tick), .gate_open(gate_open)
  );

  df_out_gate u_gate (
    .rst(rst), .ev_in(ev_in), .gate_open(gate_open),
    .final_tick(final_tick), .ev_out(ev_out)
  );

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk) rst |-> !ev_out);

  // R2
  held_back_chk: assert property (@(posedge clk) disable iff (rst)
    (!gate_open && !final_tick) |-> !ev_out);

  // R3
  kth_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_in && final_tick && !gate_open) |-> ev_out ##1 gate_open);

  // R4
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    gate_open |-> (ev_out == ev_in));

  // R6
  stays_open_chk: assert property (@(posedge clk) disable iff (rst)
    gate_open |=> gate_open);

  // R7
  reset_closes_chk: assert property (@(posedge clk)
    rst |=> !gate_open);
endmodule

// File: tb/delayed_follow_bench.sv
`timescale 1ns/1ps
module delayed_follow_bench;
  localparam int K = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_in = 1'b0;
  logic ev_out;

  int checks = 0;
  int bad = 0;
  int m_cnt = 0;
  bit m_open = 0;
  int lfsr = 32'h1ace;

  always #2 clk = ~clk;

  delayed_follow u_delayed_follow (.clk(clk), .rst(rst), .ev_in(ev_in), .ev_out(ev_out));

  // One cycle: drive on the falling edge, check shortly after, update the model at the rising edge.
  task automatic step(input bit r, input bit a, input string req);
    bit exp;
    @(negedge clk);
    rst = r;
    ev_in = a;
    #1;
    exp = !r && a && (m_open || (m_cnt == K - 1));
    checks++;
    if (ev_out !== exp) begin
      bad++;
      $display("FAIL %s: ev_out=%b expected=%b (cnt=%0d open=%0d)", req, ev_out, exp, m_cnt, m_open);
    end
    @(posedge clk);
    if (r) begin
      m_cnt = 0;
      m_open = 0;
    end else if (a && !m_open) begin
      if (m_cnt == K - 1) m_open = 1;
      else m_cnt++;
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 0, req);
  endtask

  function automatic bit next_rand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8020_0003 : 0);
    return lfsr[3];
  endfunction

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    // R8: default K matches the bench's K
    checks++;
    if (u_delayed_follow.K_START != 5) begin
      bad++;
      $display("FAIL R8: K_START=%0d expected=5", u_delayed_follow.K_START);
    end
    // R1: reset held with events present
    for (int i = 0; i < 3; i++) step(1, 1, "R1");
    step(1, 0, "R1");
    // R2 / R3: sparse events with varying gaps
    for (int e = 1; e <= K; e++) begin
      idle(e * 2, "R2");
      step(0, 1, e == K ? "R3" : "R2");
    end
    // R4: mirror under a pseudo-random pattern
    for (int i = 0; i < 60; i++) step(0, next_rand(), "R4");
    // R5: back-to-back burst after reset
    step(1, 0, "R1");
    for (int i = 0; i < K + 3; i++) step(0, 1, i == K - 1 ? "R5" : "R4");
    // R7: reset mid-count, then a full fresh count is needed
    step(1, 0, "R7");
    for (int i = 0; i < K - 2; i++) step(0, 1, "R7");
    step(1, 1, "R7");
    for (int i = 0; i < K - 1; i++) begin
      step(0, 1, "R7");
      idle(1, "R7");
    end
    step(0, 1, "R7");
    step(0, 0, "R4");
    step(0, 1, "R4");
    // R6: long run after opening, gate stays open
    for (int i = 0; i < 400; i++) step(0, (i % 3 != 0) ? 1'b1 : next_rand(), "R6");
    // R1: reset with gate open closes it
    step(1, 1, "R1");
    step(0, 1, "R2");
    step(0, 0, "R2");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule